// File: doc/BRIEF.md
# Bell 202 FSK Transmit Modulator

This block turns a serial bit line into a two-tone frequency-shift-keyed sample stream for half-duplex signalling at 1200 bit/s over a current loop. A logic 1 on the data line selects the 1200 Hz mark tone and a logic 0 selects the 2200 Hz space tone. The data line is not buffered. Its level at each phase step chooses the tone directly, so the host shifts out start, data, parity and stop bits itself at the bit rate.

Both tones come from one phase accumulator. The accumulator advances at a fixed base step rate of 460.8 kHz, which a prescaler derives from the system clock. Only the phase increment changes when the data changes, so the waveform has no phase break at a mark/space transition. The phase is mapped to a signed 8-bit trapezoid: linear ramps near each zero crossing and clipped flat tops between them. An active-low request-to-send gates the carrier. While it is high, the output sits at mid-scale (zero) and the receiver-enable output is asserted. While it is low, the receiver is blanked.

A 2-bit select tells the prescaler which of four system clock rates is in use, so the tone frequencies do not depend on that choice.

Top module: `fsk_tx_modulator`

## Requirements
- R1: While reset (`rstN` low) is applied and afterwards while `rtsN` stays high, `txSample` is 0 and `rxEnable` is 1.
- R2: With `txData` held at 1, the output tone repeats at 1200 Hz within ±1%, taking the system clock rate that `rateSel` names.
- R3: With `txData` held at 0, the output tone repeats at 2200 Hz within ±1%.
- R4: `rateSel` encodes the system clock: 0 = 460.8 kHz, 1 = 921.6 kHz, 2 = 1.8432 MHz, 3 = 3.6864 MHz. The phase advances once every 1, 2, 4 or 8 clocks respectively. One bit time at 1200 bit/s therefore lasts 3072 clocks at setting 3 and half as many for each lower setting, and the tone frequencies are the same at every setting.
- R5: While transmitting, `txSample` never changes by more than 8 codes between consecutive clocks, including at data transitions (phase-continuous switching).
- R6: The 16-bit phase p maps to the output as follows. Let i = p/64 (0..1023) and q = i mod 512. The amplitude is min(q, 511−q, 127). The sign is positive for i < 512 and negative otherwise. The output is never −128.
- R7: `txSample` shows the shaped value of the phase register one clock after that register holds it. On each step the phase advances by 171 for `txData` = 1 or by 313 for `txData` = 0, modulo 65536. While `rtsN` is high the phase is held at 0 and `txSample` is 0 from the next clock. The first two samples after `rtsN` falls (setting 0, mark) are 0 and then 2.
- R8: `rxEnable` becomes 0 one clock after `rtsN` falls and 1 one clock after it rises. `txSample` is 0 whenever `rxEnable` is 1.
- R9: `txData` is sampled at every phase step with no buffering. A change of level alters the increment used at the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (one of four rates) |
| rstN | input | 1 | Asynchronous active-low reset |
| rateSel | input | 2 | System clock rate select |
| rtsN | input | 1 | Active-low request-to-send; high gates off the carrier |
| txData | input | 1 | Serial bit line; 1 = mark, 0 = space |
| txSample | output | 8 | Signed trapezoid sample stream |
| rxEnable | output | 1 | High when the receive path may run |

## Verification
The bench drives random data toggles at every clock rate. A wrong increment or a phase reset on data change would show up as a sample jump at a transition, and would break the continuity bound. Tone periods are measured over several cycles at all four rate settings. A prescaler that misdecoded the select would give a tone that is a power of two off, far outside ±1%. The bench also drops request-to-send in the middle of a flat top and raises it again. A design that failed to clear the phase would restart from a non-zero sample, and one whose blanking lagged by a clock would show `rxEnable` high alongside a non-zero sample.

// File: rtl/fsk_tx_pkg.sv
package fsk_tx_pkg;

  // Strobes passed from the control unit to the datapath each clock
  typedef struct packed {
    logic tick;     // advance the phase this clock
    logic clear;    // hold the phase at zero
    logic useMark;  // pick the mark increment
    logic active;   // carrier is on
  } ctlStrobes_t;

endpackage

// File: rtl/fsk_tx_ctrl.sv
module fsk_tx_ctrl
  import fsk_tx_pkg::*;
#(
  parameter int RATE_SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [RATE_SEL_W-1:0] rateSel,
  input  logic                  rtsN,
  input  logic                  txData,
  output ctlStrobes_t           strobes,
  output logic                  rxEnable
);

  // Largest divide ratio the select can name, and the counter width for it
  localparam int MAX_DIV = 1 << ((1 << RATE_SEL_W) - 1);
  localparam int PRESC_W = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

  logic [PRESC_W-1:0] presCnt;
  logic [PRESC_W-1:0] divLast;
  logic               txOn;
  logic               stepNow;

  assign txOn    = ~rtsN;
  assign divLast = PRESC_W'((32'd1 << rateSel) - 32'd1);
  // ">=" keeps the prescaler sane when the rate changes mid-count
  assign stepNow = txOn && (presCnt >= divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presCnt  <= '0;
      rxEnable <= 1'b1;
    end else begin
      rxEnable <= ~txOn;
      if (!txOn || stepNow) presCnt <= '0;
      else                  presCnt <= presCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.tick    = stepNow;
    strobes.clear   = ~txOn;
    strobes.useMark = txData;
    strobes.active  = txOn;
  end

endmodule

// File: rtl/fsk_trap_shaper.sv
module fsk_trap_shaper #(
  parameter int PHASE_W  = 16,
  parameter int SAMPLE_W = 8
) (
  input  logic        [PHASE_W-1:0]  phase,
  output logic signed [SAMPLE_W-1:0] level
);

  // Index: sign bit, two segment bits, ramp position
  localparam int IDX_W = SAMPLE_W + 2;
  localparam int AMP_W = SAMPLE_W - 1;

  logic [IDX_W-1:0] idx;
  logic [1:0]       seg;
  logic [AMP_W-1:0] mag;
  logic signed [SAMPLE_W-1:0] posLevel;

  assign idx = phase[PHASE_W-1 -: IDX_W];
  assign seg = idx[IDX_W-2 -: 2];

  always_comb begin
    unique case (seg)
      2'b00:   mag = idx[AMP_W-1:0];        // rising ramp
      2'b11:   mag = ~idx[AMP_W-1:0];       // falling ramp
      default: mag = '1;                    // clipped top
    endcase
    posLevel = $signed({1'b0, mag});
    level    = idx[IDX_W-1] ? -posLevel : posLevel;
  end

endmodule

// File: rtl/fsk_tx_datapath.sv
module fsk_tx_datapath
  import fsk_tx_pkg::*;
#(
  parameter int PHASE_W   = 16,
  parameter int SAMPLE_W  = 8,
  parameter int MARK_INC  = 171,
  parameter int SPACE_INC = 313
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobes_t                strobes,
  output logic signed [SAMPLE_W-1:0] txSample
);

  localparam logic [PHASE_W-1:0] MARK_STEP  = PHASE_W'(MARK_INC);
  localparam logic [PHASE_W-1:0] SPACE_STEP = PHASE_W'(SPACE_INC);

  logic        [PHASE_W-1:0]  phaseAcc;
  logic        [PHASE_W-1:0]  phaseStep;
  logic signed [SAMPLE_W-1:0] shaped;

  assign phaseStep = strobes.useMark ? MARK_STEP : SPACE_STEP;

  fsk_trap_shaper #(
    .PHASE_W (PHASE_W),
    .SAMPLE_W(SAMPLE_W)
  ) u_shaper (
    .phase(phaseAcc),
    .level(shaped)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseAcc <= '0;
      txSample <= '0;
    end else begin
      if (strobes.clear)     phaseAcc <= '0;
      else if (strobes.tick) phaseAcc <= phaseAcc + phaseStep;
      txSample <= strobes.active ? shaped : '0;
    end
  end

endmodule

// File: rtl/fsk_tx_modulator.sv
module fsk_tx_modulator
  import fsk_tx_pkg::*;
#(
  parameter int BASE_HZ    = 460800,
  parameter int MARK_HZ    = 1200,
  parameter int SPACE_HZ   = 2200,
  parameter int PHASE_W    = 16,
  parameter int SAMPLE_W   = 8,
  parameter int RATE_SEL_W = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [RATE_SEL_W-1:0]      rateSel,
  input  logic                       rtsN,
  input  logic                       txData,
  output logic signed [SAMPLE_W-1:0] txSample,
  output logic                       rxEnable
);

  // Rounded phase increments per base-rate step
  localparam int MARK_INC  = (MARK_HZ  * (1 << PHASE_W) + BASE_HZ / 2) / BASE_HZ;
  localparam int SPACE_INC = (SPACE_HZ * (1 << PHASE_W) + BASE_HZ / 2) / BASE_HZ;

  ctlStrobes_t strobes;

  fsk_tx_ctrl #(
    .RATE_SEL_W(RATE_SEL_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rateSel (rateSel),
    .rtsN    (rtsN),
    .txData  (txData),
    .strobes (strobes),
    .rxEnable(rxEnable)
  );

  fsk_tx_datapath #(
    .PHASE_W  (PHASE_W),
    .SAMPLE_W (SAMPLE_W),
    .MARK_INC (MARK_INC),
    .SPACE_INC(SPACE_INC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .txSample(txSample)
  );

endmodule

// File: rtl/fsk_tx_checker.sv
module fsk_tx_checker #(
  parameter int SAMPLE_W = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       rtsN,
  input logic                       rxEnable,
  input logic signed [SAMPLE_W-1:0] txSample
);

  logic signed [SAMPLE_W-1:0] prevSample;
  logic                       prevTx;
  logic signed [SAMPLE_W:0]   stepDiff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSample <= '0;
      prevTx     <= 1'b0;
    end else begin
      prevSample <= txSample;
      prevTx     <= ~rxEnable;
    end
  end

  assign stepDiff = {txSample[SAMPLE_W-1], txSample} - {prevSample[SAMPLE_W-1], prevSample};

  // R7: carrier off forces mid-scale on the next clock
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    rtsN |=> (txSample == '0));

  // R8: receiver enable tracks request-to-send with one clock delay
  p_rx_on_r8: assert property (@(posedge clk) disable iff (!rstN)
    rtsN |=> rxEnable);
  p_rx_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rtsN |=> !rxEnable);

  // R8: receiver never enabled while a non-zero sample is driven
  p_blank_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable |-> (txSample == '0));

  // R5: no phase break, bounded step between consecutive samples
  p_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && prevTx) |-> (stepDiff <= 8 && stepDiff >= -8));

  // R6: symmetric range, most negative code never produced
  p_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    txSample != {1'b1, {(SAMPLE_W-1){1'b0}}});

endmodule

bind fsk_tx_modulator fsk_tx_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .rtsN    (rtsN),
  .rxEnable(rxEnable),
  .txSample(txSample)
);

// File: tb/fsk_tx_modulator_tb.sv
module fsk_tx_modulator_tb;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        rateSel = 2'd0;
  logic              rtsN = 1'b1;
  logic              txData = 1'b1;
  logic signed [7:0] txSample;
  logic              rxEnable;

  always #5 clk = ~clk;

  fsk_tx_modulator u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .rateSel (rateSel),
    .rtsN    (rtsN),
    .txData  (txData),
    .txSample(txSample),
    .rxEnable(rxEnable)
  );

  int     total = 0;
  int     bad = 0;
  longint cyc = 0;
  bit     finished = 0;

  // Behavioural reference state
  int refPres = 0;
  int refPhase = 0;
  int refSample = 0;
  bit refRx = 1;

  function automatic int trapRef(int ph);
    int i, q, a;
    i = ph / 64;
    q = i % 512;
    a = q;
    if (511 - q < a) a = 511 - q;
    if (127 < a) a = 127;
    return (i >= 512) ? -a : a;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // Reference model advanced every clock (R4 R7 R9)
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPres = 0; refPhase = 0; refSample = 0; refRx = 1;
    end else begin
      int div;
      bit on;
      int nextSample;
      div = 1 << rateSel;
      on = !rtsN;
      nextSample = on ? trapRef(refPhase) : 0;
      refRx = !on;
      if (!on) begin
        refPres = 0; refPhase = 0;
      end else if (refPres >= div - 1) begin
        refPres = 0;
        refPhase = (refPhase + (txData ? 171 : 313)) % 65536;
      end else begin
        refPres = refPres + 1;
      end
      refSample = nextSample;
    end
  end

  // Per-clock comparison against the model (R6 R9 R8)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(txSample == refSample, "R6 R9 sample", txSample, refSample);
      check(rxEnable == refRx, "R8 rxEnable", rxEnable, refRx);
    end
  end

  // Measure four tone periods from upward zero crossings
  task automatic measureTone(input logic [1:0] sel, input bit mark, input string req);
    int     div;
    longint sys, t0, t1, err;
    int     f, seen, prev;
    div = 1 << sel;
    sys = 64'd460800 * div;
    f = mark ? 1200 : 2200;
    seen = 0; t0 = 0; t1 = 0;
    @(negedge clk);
    rateSel = sel; txData = mark; rtsN = 1'b0;
    @(negedge clk);
    prev = txSample;
    while (seen < 5) begin
      @(negedge clk);
      if (prev <= 0 && txSample > 0) begin
        if (seen == 0) t0 = cyc;
        t1 = cyc;
        seen++;
      end
      prev = txSample;
    end
    err = (t1 - t0) * f - 4 * sys;
    if (err < 0) err = -err;
    check(err * 100 <= 4 * sys, req, (t1 - t0) / 4, sys / f);
  endtask

  initial begin
    int  lfsr;
    bit  allZero;
    repeat (4) @(negedge clk);
    check(txSample == 0, "R1 sample in reset", txSample, 0);
    check(rxEnable == 1'b1, "R1 rxEnable in reset", rxEnable, 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(txSample == 0, "R1 sample idle", txSample, 0);
    check(rxEnable == 1'b1, "R1 rxEnable idle", rxEnable, 1);

    // Carrier on at setting 0 with mark
    rateSel = 2'd0; txData = 1'b1; rtsN = 1'b0;
    @(negedge clk);
    check(rxEnable == 1'b0, "R8 blank after rts", rxEnable, 0);
    check(txSample == 0, "R7 first sample", txSample, 0);
    @(negedge clk);
    check(txSample == 2, "R7 second sample", txSample, 2);

    measureTone(2'd0, 1'b1, "R2 mark sel0");
    measureTone(2'd0, 1'b0, "R3 space sel0");
    measureTone(2'd1, 1'b1, "R4 mark sel1");
    measureTone(2'd2, 1'b0, "R4 space sel2");
    measureTone(2'd3, 1'b1, "R4 mark sel3");
    measureTone(2'd3, 1'b0, "R3 space sel3");

    // Random data at several rates: continuity and sampling (R5 R9)
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      lfsr = ((lfsr >> 1) | (((lfsr ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
      txData = lfsr[0];
      if (n % 1000 == 0) rateSel = 2'(n / 1000);
    end

    // Drop the carrier mid-wave; inputs then have no effect (R7 R8)
    rateSel = 2'd0; txData = 1'b1;
    repeat (100) @(negedge clk);
    rtsN = 1'b1;
    @(negedge clk);
    check(txSample == 0, "R7 zero after rts high", txSample, 0);
    check(rxEnable == 1'b1, "R8 rx back on", rxEnable, 1);
    allZero = 1;
    for (int n = 0; n < 30; n++) begin
      txData = ~txData;
      rateSel = 2'(n);
      @(negedge clk);
      if (txSample != 0) allZero = 0;
    end
    check(allZero, "R7 idle ignores data", txSample, 0);

    // Reassert: phase restarts from zero
    rateSel = 2'd0; txData = 1'b1; rtsN = 1'b0;
    @(negedge clk);
    check(txSample == 0, "R7 restart first", txSample, 0);
    @(negedge clk);
    check(txSample == 2, "R7 restart second", txSample, 2);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 190000 && !finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule